// File: doc/BRIEF.md
# Multidrop Receive Address Filter

This block sits between the receive shift register of a 9-bit serial receiver and the receive FIFO. It decides which received characters are written into the FIFO. Every character carries a ninth flag bit that marks it as an address byte or a data byte. Address bytes are compared with a programmable 8-bit station address.

A receiver-disable bit controls the filter. While the receiver is enabled, every character is stored. An address byte that does not match the station address sets the disable bit in hardware, and that byte is discarded. While the receiver is disabled, data bytes and foreign address bytes are dropped. An address byte that matches clears the disable bit and is stored.

The host can write the disable bit and the station address at any cycle through a small register port, and can read both back. A FIFO-full input stops writes. A byte that should have been stored while the FIFO is full raises a one-cycle overrun pulse.

Top module: `rs485_addr_filter`

## Requirements
- R1: After reset, `rx_disabled` equals parameter DIS_RESET (default 0), `station_addr` is 0x00, and `fifo_wr` and `overrun` are low.
- R2: The character format is fixed. `rx_char[8]`=1 marks an address byte and 0 marks a data byte, and `rx_char[7:0]` is the payload. While the receiver is enabled, each data byte and each matching address byte produces `fifo_wr` in the cycle after `rx_valid`. In that cycle `fifo_wdata` equals the full 9-bit character.
- R3: An address byte whose `rx_char[7:0]` differs from `station_addr` is never written, and it leaves `rx_disabled`=1 from the next cycle on. This holds whether the receiver was enabled or disabled.
- R4: While `rx_disabled`=1, a data byte produces no FIFO write and no overrun.
- R5: While `rx_disabled`=1, an address byte equal to `station_addr` clears `rx_disabled` in the next cycle and is written to the FIFO.
- R6: A host write (`host_dis_we` or `host_addr_we`) updates `rx_disabled` or `station_addr` in the next cycle when no hardware event occurs. A character in the same cycle is judged against the values from before the write.
- R7: A hardware set or clear of the disable bit, caused by a received address byte, takes priority over a host write of the disable bit in the same cycle.
- R8: When `fifo_full` is high in the `rx_valid` cycle, a byte that would have been stored is dropped instead, and `overrun` pulses for one cycle in the next cycle. The disable bit is still updated as in R3 and R5.
- R9: `fifo_wr` and `overrun` are single-cycle pulses, each following an `rx_valid` in the previous cycle, and the two are never high together. Back-to-back characters are each handled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | One-cycle strobe: a character is ready |
| rx_char | input | 9 | Received character; bit 8 is the address flag |
| fifo_full | input | 1 | Receive FIFO cannot accept a write |
| host_dis_we | input | 1 | Host write strobe for the disable bit |
| host_dis_val | input | 1 | Value written to the disable bit |
| host_addr_we | input | 1 | Host write strobe for the station address |
| host_addr_val | input | 8 | Value written to the station address |
| fifo_wr | output | 1 | FIFO write strobe |
| fifo_wdata | output | 9 | Character written to the FIFO |
| overrun | output | 1 | One-cycle pulse: a byte was lost to a full FIFO |
| rx_disabled | output | 1 | Current receiver-disable bit (1 = disabled) |
| station_addr | output | 8 | Current station address |

## Verification
The embedded assertions check the following on every cycle:
- a foreign address byte is never written and always leaves the receiver disabled;
- a data byte is never stored while the receiver is disabled;
- a matching address byte always re-enables the receiver;
- a hardware event always wins over a host write;
- the write and overrun strobes are exclusive pulses, each tied to a preceding valid strobe.

Only the bench's scenarios can show other behaviour. These include the exact 9-bit value carried to the FIFO and the cycle in which host writes take effect. They also include the use of the old station address for a character that arrives together with an address write, and full-FIFO handling across all three kinds of character. A reference model in the bench is compared with every output on every clock.

// File: rtl/rs485_filt_pkg.sv
package rs485_filt_pkg;

  typedef struct packed {
    logic store;   // character belongs in the FIFO
    logic hw_set;  // force the receiver off
    logic hw_clr;  // force the receiver on
  } filt_verdict_t;

  // Decide the fate of one character from its kind, its compare result and
  // the current receiver state.
  function automatic filt_verdict_t judge(input logic is_addr,
                                          input logic hit,
                                          input logic off);
    filt_verdict_t v;
    v.hw_set = is_addr && !hit;
    v.hw_clr = is_addr && hit && off;
    if (off) v.store = is_addr && hit;
    else     v.store = !(is_addr && !hit);
    return v;
  endfunction

  // Next value of the disable bit; hardware events outrank the host.
  function automatic logic next_disable(input logic cur,
                                        input logic hw_set,
                                        input logic hw_clr,
                                        input logic host_we,
                                        input logic host_val);
    if (hw_set)       return 1'b1;
    else if (hw_clr)  return 1'b0;
    else if (host_we) return host_val;
    return cur;
  endfunction

endpackage

// File: rtl/filt_cfg_regs.sv
module filt_cfg_regs #(
  parameter int  ADDR_W    = 8,
  parameter bit  DIS_RESET = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_dis_we,
  input  logic              host_dis_val,
  input  logic              host_addr_we,
  input  logic [ADDR_W-1:0] host_addr_val,
  input  logic              hw_set,
  input  logic              hw_clr,
  output logic              disabled,
  output logic [ADDR_W-1:0] match_val
);
  import rs485_filt_pkg::*;

  logic dis_nxt;
  assign dis_nxt = next_disable(disabled, hw_set, hw_clr, host_dis_we, host_dis_val);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      disabled  <= DIS_RESET;
      match_val <= '0;
    end else begin
      disabled <= dis_nxt;
      if (host_addr_we) match_val <= host_addr_val;
    end
  end

  // R7
  hw_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hw_set |=> disabled);
  // R7
  hw_clr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_clr && !hw_set) |=> !disabled);
  // R6
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !host_addr_we |=> $stable(match_val));
endmodule

// File: rtl/filt_classify.sv
module filt_classify #(
  parameter int ADDR_W = 8,
  localparam int CHAR_W = ADDR_W + 1
) (
  input  logic              valid,
  input  logic [CHAR_W-1:0] ch,
  input  logic [ADDR_W-1:0] match_val,
  input  logic              disabled,
  output logic              store_req,
  output logic              hw_set,
  output logic              hw_clr
);
  import rs485_filt_pkg::*;

  logic          is_addr;
  logic          hit;
  filt_verdict_t verdict;

  assign is_addr = ch[CHAR_W-1];
  assign hit     = (ch[ADDR_W-1:0] == match_val);
  assign verdict = judge(is_addr, hit, disabled);

  assign store_req = valid && verdict.store;
  assign hw_set    = valid && verdict.hw_set;
  assign hw_clr    = valid && verdict.hw_clr;
endmodule

// File: rtl/filt_write_stage.sv
module filt_write_stage #(
  parameter int CHAR_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              store_req,
  input  logic              full,
  input  logic [CHAR_W-1:0] ch,
  output logic              wr,
  output logic [CHAR_W-1:0] wdata,
  output logic              over
);
  logic accept;
  logic lost;
  assign accept = store_req && !full;
  assign lost   = store_req && full;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr    <= 1'b0;
      over  <= 1'b0;
      wdata <= '0;
    end else begin
      wr   <= accept;
      over <= lost;
      if (accept) wdata <= ch;
    end
  end

  // R9
  wr_over_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr && over));
  // R8
  full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (store_req && full) |=> (over && !wr));
  // R2
  accept_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (store_req && !full) |=> (wr && wdata == $past(ch)));
endmodule

// File: rtl/rs485_addr_filter.sv
module rs485_addr_filter #(
  parameter int ADDR_W    = 8,
  parameter bit DIS_RESET = 1'b0,
  localparam int CHAR_W   = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  input  logic [CHAR_W-1:0] rx_char,
  input  logic              fifo_full,
  input  logic              host_dis_we,
  input  logic              host_dis_val,
  input  logic              host_addr_we,
  input  logic [ADDR_W-1:0] host_addr_val,
  output logic              fifo_wr,
  output logic [CHAR_W-1:0] fifo_wdata,
  output logic              overrun,
  output logic              rx_disabled,
  output logic [ADDR_W-1:0] station_addr
);
  logic store_req;
  logic hw_set;
  logic hw_clr;

  filt_cfg_regs #(.ADDR_W(ADDR_W), .DIS_RESET(DIS_RESET)) u_cfg (
    .clk(clk), .rst_n(rst_n),
    .host_dis_we(host_dis_we), .host_dis_val(host_dis_val),
    .host_addr_we(host_addr_we), .host_addr_val(host_addr_val),
    .hw_set(hw_set), .hw_clr(hw_clr),
    .disabled(rx_disabled), .match_val(station_addr)
  );

  filt_classify #(.ADDR_W(ADDR_W)) u_cls (
    .valid(rx_valid), .ch(rx_char), .match_val(station_addr),
    .disabled(rx_disabled), .store_req(store_req),
    .hw_set(hw_set), .hw_clr(hw_clr)
  );

  filt_write_stage #(.CHAR_W(CHAR_W)) u_wr (
    .clk(clk), .rst_n(rst_n), .store_req(store_req), .full(fifo_full),
    .ch(rx_char), .wr(fifo_wr), .wdata(fifo_wdata), .over(overrun)
  );

  // R3
  foreign_addr_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_char[CHAR_W-1] && rx_char[ADDR_W-1:0] != station_addr)
      |=> (!fifo_wr && !overrun && rx_disabled));
  // R4
  off_data_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_char[CHAR_W-1] && rx_disabled) |=> (!fifo_wr && !overrun));
  // R5
  own_addr_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_char[CHAR_W-1] && rx_char[ADDR_W-1:0] == station_addr && rx_disabled)
      |=> (!rx_disabled && (fifo_wr || overrun)));
  // R9
  wr_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_wr || overrun) |-> $past(rx_valid));
endmodule

// File: tb/test_rs485_addr_filter.sv
module test_rs485_addr_filter;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_valid = 1'b0;
  logic [8:0] rx_char = '0;
  logic       fifo_full = 1'b0;
  logic       host_dis_we = 1'b0;
  logic       host_dis_val = 1'b0;
  logic       host_addr_we = 1'b0;
  logic [7:0] host_addr_val = '0;
  logic       fifo_wr;
  logic [8:0] fifo_wdata;
  logic       overrun;
  logic       rx_disabled;
  logic [7:0] station_addr;

  always #5 clk = ~clk;

  rs485_addr_filter i_rs485_addr_filter (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_char(rx_char),
    .fifo_full(fifo_full), .host_dis_we(host_dis_we), .host_dis_val(host_dis_val),
    .host_addr_we(host_addr_we), .host_addr_val(host_addr_val),
    .fifo_wr(fifo_wr), .fifo_wdata(fifo_wdata), .overrun(overrun),
    .rx_disabled(rx_disabled), .station_addr(station_addr)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  // reference model state
  bit       m_off = 0;
  bit [7:0] m_sta = 8'h00;
  bit       e_wr = 0;
  bit       e_ov = 0;
  bit [8:0] e_dat = '0;
  bit [8:0] wr_log[$];

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic compare(input string tag);
    chk(tag, "fifo_wr", fifo_wr, e_wr);
    chk(tag, "overrun", overrun, e_ov);
    chk(tag, "rx_disabled", rx_disabled, m_off);
    chk(tag, "station_addr", station_addr, m_sta);
    if (e_wr) chk(tag, "fifo_wdata", fifo_wdata, e_dat);
  endtask

  // One clock: drive at negedge, advance model at posedge, compare at next negedge.
  task automatic step(input bit v, input bit [8:0] ch, input bit full,
                      input bit dwe, input bit dval, input bit awe, input bit [7:0] aval,
                      input string tag);
    bit is_a, hit, keep;
    rx_valid = v; rx_char = ch; fifo_full = full;
    host_dis_we = dwe; host_dis_val = dval; host_addr_we = awe; host_addr_val = aval;
    @(posedge clk);
    is_a = ch[8];
    hit  = (ch[7:0] == m_sta);
    keep = 0;
    if (v) keep = m_off ? (is_a && hit) : !(is_a && !hit);
    e_wr = keep && !full;
    e_ov = keep && full;
    if (e_wr) begin e_dat = ch; wr_log.push_back(ch); end
    if (v && is_a && !hit)            m_off = 1;
    else if (v && is_a && hit && m_off) m_off = 0;
    else if (dwe)                     m_off = dval;
    if (awe) m_sta = aval;
    @(negedge clk);
    compare(tag);
  endtask

  task automatic rx(input bit [8:0] ch, input string tag);
    step(1, ch, 0, 0, 0, 0, 8'h00, tag);
  endtask

  task automatic idle(input string tag);
    step(0, 9'h000, 0, 0, 0, 0, 8'h00, tag);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state while reset held, then after release
    compare("R1");
    rst_n = 1'b1;
    idle("R1");

    // R2: enabled, data and matching address (0x00) stored with flag kept
    rx(9'h055, "R2");
    rx(9'h100, "R2");
    idle("R2");
    rx(9'h0FF, "R2");

    // R6: host programs station address 0x3C
    step(0, 9'h000, 0, 0, 0, 1, 8'h3C, "R6");
    rx(9'h13C, "R2");
    // R3: foreign address disables and is dropped
    rx(9'h111, "R3");
    // R4: data while disabled dropped
    rx(9'h03C, "R4");
    rx(9'h0A5, "R4");
    // R3: foreign address while disabled stays dropped
    rx(9'h1C3, "R3");
    // R5: own address wakes and is stored, then data flows
    rx(9'h13C, "R5");
    rx(9'h012, "R5");

    // R6: host disables, data dropped, host enables
    step(0, 9'h000, 0, 1, 1, 0, 8'h00, "R6");
    rx(9'h077, "R6");
    step(0, 9'h000, 0, 1, 0, 0, 8'h00, "R6");
    rx(9'h078, "R6");
    // R6: address compared against old station value in the write cycle
    step(1, 9'h13C, 0, 0, 0, 1, 8'h5A, "R6");
    rx(9'h15A, "R6");

    // R7: foreign address beats host enable write
    step(1, 9'h101, 0, 1, 0, 0, 8'h00, "R7");
    // R7: own address beats host disable write
    step(1, 9'h15A, 0, 1, 1, 0, 8'h00, "R7");
    idle("R7");

    // R8: full FIFO
    step(1, 9'h033, 1, 0, 0, 0, 8'h00, "R8");
    step(1, 9'h102, 1, 0, 0, 0, 8'h00, "R8");
    step(1, 9'h044, 1, 0, 0, 0, 8'h00, "R8");
    step(1, 9'h15A, 1, 0, 0, 0, 8'h00, "R8");
    rx(9'h066, "R8");

    // R9: back-to-back characters
    for (int i = 0; i < 8; i++) rx({i[0], 8'h58 + 8'(i)}, "R9");
    idle("R9");

    // Mixed traffic from an LFSR
    begin
      bit [15:0] lf = 16'hACE1;
      for (int i = 0; i < 400; i++) begin
        bit [8:0] ch;
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
        ch = {lf[0], (lf[3:1] == 0) ? m_sta : lf[15:8]};
        step(lf[4] | lf[5], ch, lf[6] & lf[7] & lf[8], lf[9] & lf[10] & lf[11], lf[12],
             (lf[13:11] == 3'b111), lf[7:0], "R9");
      end
    end
    chk("R2", "write count nonzero", (wr_log.size() > 10), 1);
    finish_run();
  end
endmodule